// File: doc/BRIEF.md
# Embedded-Clock Framing Serializer

This block turns a parallel data word into a serial stream that carries its own clock. Each word is wrapped between a leading one and a trailing zero, so the stream has a fixed rising and falling transition in every frame. A receiver can recover the word clock from these two framing bits. The whole block runs on the fast bit clock. A one-cycle word strobe, issued once per frame period by the surrounding logic, marks each frame boundary. The edge-select flag is registered as a mode bit. It decides where in the word period the parallel input is captured.

To help a remote receiver acquire lock, the block can replace data frames with a synchronisation symbol. The symbol is a half-frame of ones followed by a half-frame of zeros. A sync request always produces a minimum burst of these symbols. The output is undriven in three cases: while powered down, for a fixed number of word periods after power returns, and whenever the output enable is low.

Top module: `ecfs_serializer`

## Requirements
- R1: A data frame is DATA_W+2 bits long and is sent least significant bit first. Bit 0 is a start bit that is always 1. Bits 1..DATA_W are the captured word, with word bit 0 sent first. The last bit is a stop bit that is always 0.
- R2: A frame begins on the bit clock after each word strobe, and each frame bit lasts one bit clock. The frame loaded at a strobe carries the word captured during the previous word period.
- R3: With edge_rise high, the word is captured from din in the strobe cycle. With edge_rise low, it is captured FRAME_W/2+1 bit clocks after the strobe, which is the middle of the word period.
- R4: A sync symbol is FRAME_W bits long: FRAME_W/2 ones sent first, then FRAME_W/2 zeros. While a sync symbol is sent, din has no effect on the serial bits.
- R5: The sync request is the OR of sync_a and sync_b. It is sampled only at the word strobe, so a pulse that starts and ends between strobes has no effect.
- R6: Once a sync request is seen, at least SYNC_MIN consecutive sync symbols are sent. Symbols keep being sent while the request stays high. Data resumes at the first strobe where the request is low and SYNC_MIN symbols have been sent.
- R7: While pwr_on is low, sdo_en, sdo and ready are 0 from the next bit clock on, and any sync burst in progress is dropped.
- R8: After pwr_on rises, the first LOCK_WORDS word strobes send nothing and the next strobe starts the first frame. ready rises at the LOCK_WORDS-th strobe.
- R9: While oe is low, sdo_en and sdo are 0, but framing, sync counting and capture carry on. When oe rises again, output resumes with the stream the block would have sent anyway.
- R10: During reset, sdo, sdo_en and ready are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_stb | input | 1 | One-cycle frame boundary strobe, once per word period |
| din | input | DATA_W | Parallel data word |
| sync_a | input | 1 | Sync request, first line |
| sync_b | input | 1 | Sync request, second line |
| oe | input | 1 | Output enable |
| pwr_on | input | 1 | High to run, low for power-down |
| edge_rise | input | 1 | Capture point select: high at strobe, low at mid-period |
| sdo | output | 1 | Serial data bit, 0 when not driven |
| sdo_en | output | 1 | Output drive enable |
| ready | output | 1 | Lock interval complete, block running |

## Verification
The bench builds the block with DATA_W=10, SYNC_MIN=4 and LOCK_WORDS=3. These values keep the real frame width and shrink the burst and lock intervals. This makes it cheap to walk through the full lock interval after each power-up. It also lets the bench cover a minimum burst, an extended burst, a burst interrupted by enable and by power-down, and mid-period sync pulses. Each frame is compared bit by bit against a frame the bench builds arithmetically from the word it drove one period earlier. Data patterns are swept in both capture modes.

// File: rtl/ecfs_pkg.sv
package ecfs_pkg;

  // Run state of the serializer control
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_LOCK = 2'd1,
    ST_RUN  = 2'd2
  } ecfs_state_t;

  // Frame width from payload width: one start bit and one stop bit
  function automatic int frame_len(input int data_w);
    return data_w + 2;
  endfunction

endpackage

// File: rtl/ecfs_ctrl.sv
module ecfs_ctrl
  import ecfs_pkg::*;
#(
  parameter int SYNC_MIN   = 1024,
  parameter int LOCK_WORDS = 510,
  localparam int CNT_W = $clog2(SYNC_MIN + 1),
  localparam int LK_W  = $clog2(LOCK_WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_on,
  input  logic             word_stb,
  input  logic             sync_req,
  output logic             load_frame,
  output logic             load_sync,
  output logic             ready,
  output logic             sync_on_o,
  output logic [CNT_W-1:0] sync_cnt_o
);

  ecfs_state_t      st;
  logic [LK_W-1:0]  lock_cnt;
  logic             sync_on;
  logic [CNT_W-1:0] sync_cnt;
  logic             burst_short;
  logic             lock_done;

  // Saturating increment of the burst counter
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    return (c >= CNT_W'(SYNC_MIN)) ? c : c + 1'b1;
  endfunction

  assign burst_short = sync_on && (sync_cnt < CNT_W'(SYNC_MIN));
  assign lock_done   = word_stb && (lock_cnt == LK_W'(LOCK_WORDS - 1));
  assign load_frame  = word_stb && pwr_on && (st == ST_RUN);
  assign load_sync   = load_frame && (sync_req || burst_short);

  always_ff @(posedge clk) begin
    if (!rst_n || !pwr_on) begin
      st       <= ST_OFF;
      lock_cnt <= '0;
      sync_on  <= 1'b0;
      sync_cnt <= '0;
    end else begin
      case (st)
        ST_OFF: begin
          st       <= ST_LOCK;
          lock_cnt <= '0;
        end
        ST_LOCK: begin
          if (lock_done) st <= ST_RUN;
          else if (word_stb) lock_cnt <= lock_cnt + 1'b1;
        end
        default: begin
          if (load_sync) begin
            sync_on  <= 1'b1;
            sync_cnt <= sync_on ? sat_inc(sync_cnt) : CNT_W'(1);
          end else if (load_frame) begin
            sync_on  <= 1'b0;
            sync_cnt <= '0;
          end
        end
      endcase
    end
  end

  assign ready      = (st == ST_RUN);
  assign sync_on_o  = sync_on;
  assign sync_cnt_o = sync_cnt;

endmodule

// File: rtl/ecfs_shifter.sv
module ecfs_shifter
  import ecfs_pkg::*;
#(
  parameter int DATA_W = 10,
  localparam int FRAME_W = frame_len(DATA_W),
  localparam int HALF    = FRAME_W / 2,
  localparam int PH_W    = $clog2(FRAME_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_on,
  input  logic              edge_rise,
  input  logic              word_stb,
  input  logic [DATA_W-1:0] din,
  input  logic              load_frame,
  input  logic              load_sync,
  output logic              tx_bit,
  output logic              live
);

  logic               edge_q;
  logic [PH_W-1:0]    phase;
  logic [DATA_W-1:0]  cap;
  logic [FRAME_W-1:0] shreg;
  logic               cap_rise;
  logic               cap_fall;

  // Start bit in position 0, stop bit at the top, word bit 0 after start
  function automatic logic [FRAME_W-1:0] frame_word(input logic [DATA_W-1:0] d);
    return {1'b0, d, 1'b1};
  endfunction

  // Half frame of ones sent first, then half frame of zeros
  function automatic logic [FRAME_W-1:0] sync_word();
    return {{(FRAME_W - HALF){1'b0}}, {HALF{1'b1}}};
  endfunction

  assign cap_rise = edge_q && word_stb;
  assign cap_fall = !edge_q && !word_stb && (phase == PH_W'(HALF));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edge_q <= 1'b1;
      phase  <= '0;
      cap    <= '0;
    end else begin
      edge_q <= edge_rise;
      if (word_stb) phase <= '0;
      else if (phase != PH_W'(FRAME_W - 1)) phase <= phase + 1'b1;
      if (cap_rise || cap_fall) cap <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !pwr_on) begin
      shreg <= '0;
      live  <= 1'b0;
    end else if (load_sync) begin
      shreg <= sync_word();
      live  <= 1'b1;
    end else if (load_frame) begin
      shreg <= frame_word(cap);
      live  <= 1'b1;
    end else begin
      shreg <= shreg >> 1;
      if (word_stb) live <= 1'b0;
    end
  end

  assign tx_bit = shreg[0];

endmodule

// File: rtl/ecfs_serializer.sv
module ecfs_serializer
  import ecfs_pkg::*;
#(
  parameter int DATA_W     = 10,
  parameter int SYNC_MIN   = 1024,
  parameter int LOCK_WORDS = 510,
  localparam int CNT_W = $clog2(SYNC_MIN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_stb,
  input  logic [DATA_W-1:0] din,
  input  logic              sync_a,
  input  logic              sync_b,
  input  logic              oe,
  input  logic              pwr_on,
  input  logic              edge_rise,
  output logic              sdo,
  output logic              sdo_en,
  output logic              ready
);

  logic             sync_req;
  logic             load_frame;
  logic             load_sync;
  logic             sync_on;
  logic [CNT_W-1:0] sync_cnt;
  logic             tx_bit;
  logic             live;

  assign sync_req = sync_a | sync_b;

  ecfs_ctrl #(
    .SYNC_MIN  (SYNC_MIN),
    .LOCK_WORDS(LOCK_WORDS)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_on    (pwr_on),
    .word_stb  (word_stb),
    .sync_req  (sync_req),
    .load_frame(load_frame),
    .load_sync (load_sync),
    .ready     (ready),
    .sync_on_o (sync_on),
    .sync_cnt_o(sync_cnt)
  );

  ecfs_shifter #(
    .DATA_W(DATA_W)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_on    (pwr_on),
    .edge_rise (edge_rise),
    .word_stb  (word_stb),
    .din       (din),
    .load_frame(load_frame),
    .load_sync (load_sync),
    .tx_bit    (tx_bit),
    .live      (live)
  );

  assign sdo_en = oe && live;
  assign sdo    = sdo_en && tx_bit;

endmodule

// File: rtl/ecfs_sva.sv
module ecfs_sva #(
  parameter int SYNC_MIN   = 1024,
  parameter int LOCK_WORDS = 510,
  localparam int CNT_W = $clog2(SYNC_MIN + 1),
  localparam int OW    = $clog2(LOCK_WORDS + 2)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_on,
  input logic             oe,
  input logic             word_stb,
  input logic             sync_req,
  input logic             sdo,
  input logic             sdo_en,
  input logic             ready,
  input logic             load_frame,
  input logic             load_sync,
  input logic             sync_on,
  input logic [CNT_W-1:0] sync_cnt,
  input logic             tx_bit
);

  // Strobes seen since power came up, saturating
  logic [OW-1:0] on_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n || !pwr_on) on_cnt <= '0;
    else if (word_stb && on_cnt != OW'(LOCK_WORDS + 1)) on_cnt <= on_cnt + 1'b1;
  end

  a_r7_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> (!sdo_en && !ready));

  a_r9_undriven_low: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_en |-> !sdo);

  a_r9_oe_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !sdo_en);

  a_r8_lock_wait: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_en |-> (on_cnt > OW'(LOCK_WORDS)));

  a_r1_start_high: assert property (@(posedge clk) disable iff (!rst_n)
    load_frame |=> tx_bit);

  a_r5_req_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (load_frame && sync_req) |-> load_sync);

  a_r6_min_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (load_frame && sync_on && sync_cnt < CNT_W'(SYNC_MIN)) |-> load_sync);

endmodule

bind ecfs_serializer ecfs_sva #(
  .SYNC_MIN  (SYNC_MIN),
  .LOCK_WORDS(LOCK_WORDS)
) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwr_on    (pwr_on),
  .oe        (oe),
  .word_stb  (word_stb),
  .sync_req  (sync_req),
  .sdo       (sdo),
  .sdo_en    (sdo_en),
  .ready     (ready),
  .load_frame(load_frame),
  .load_sync (load_sync),
  .sync_on   (sync_on),
  .sync_cnt  (sync_cnt),
  .tx_bit    (tx_bit)
);

// File: tb/tb_ecfs_serializer.sv
module tb_ecfs_serializer;

  localparam int DW   = 10;
  localparam int FW   = DW + 2;
  localparam int SMIN = 4;
  localparam int LOCK = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stb = 1'b0;
  logic [DW-1:0] din = '0;
  logic          sa = 1'b0, sb = 1'b0;
  logic          oe = 1'b1, pwr = 1'b1, edge_r = 1'b1;
  logic          sdo, sdo_en, ready;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench-side model state
  logic [DW-1:0] cap_m = '0;
  int on_words = 0;
  bit burst = 0;
  int sent = 0;

  always #5 clk = ~clk;

  ecfs_serializer #(.DATA_W(DW), .SYNC_MIN(SMIN), .LOCK_WORDS(LOCK)) dut (
    .clk(clk), .rst_n(rst_n), .word_stb(stb), .din(din),
    .sync_a(sa), .sync_b(sb), .oe(oe), .pwr_on(pwr), .edge_rise(edge_r),
    .sdo(sdo), .sdo_en(sdo_en), .ready(ready)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      stb = 1'b0;
      @(negedge clk);
    end
  endtask

  // One word period; starts and ends at a falling clock edge.
  task automatic word(input logic [DW-1:0] a, input logic [DW-1:0] b,
                      input logic [1:0] sy_stb, input logic [1:0] sy_mid, input string tag);
    logic [FW-1:0] got_b, got_e, exp_b;
    bit sending, is_sync, exp_rdy;
    // expectation from the requirements
    if (!pwr) begin
      on_words = 0; burst = 0; sent = 0;
    end else if (on_words < LOCK + 1) on_words++;
    sending = pwr && (on_words == LOCK + 1);            // R8
    exp_rdy = pwr && (on_words >= LOCK);
    is_sync = 0;
    if (sending) begin
      if (|sy_stb) begin                                  // R5 OR of the two lines
        if (!burst) begin burst = 1; sent = 1; end
        else if (sent < SMIN) sent++;
        is_sync = 1;
      end else if (burst && sent < SMIN) begin            // R6 minimum burst
        sent++; is_sync = 1;
      end else begin
        burst = 0; sent = 0;
      end
    end
    for (int i = 0; i < FW; i++) begin
      if (!(sending && oe)) exp_b[i] = 1'b0;
      else if (is_sync) exp_b[i] = (i < FW / 2);          // R4
      else if (i == 0) exp_b[i] = 1'b1;                   // R1 start
      else if (i == FW - 1) exp_b[i] = 1'b0;              // R1 stop
      else exp_b[i] = cap_m[i-1];
    end
    // drive and sample
    stb = 1'b1; din = a; {sb, sa} = sy_stb;
    for (int i = 0; i < FW; i++) begin
      @(negedge clk);
      got_b[i] = sdo;
      got_e[i] = sdo_en;
      stb = 1'b0;
      din = b;
      {sb, sa} = sy_mid;
    end
    cap_m = edge_r ? a : b;                               // R3
    chk(got_e == ((sending && oe) ? {FW{1'b1}} : {FW{1'b0}}),
        {tag, " enable"}, 32'(got_e), 32'((sending && oe) ? {FW{1'b1}} : {FW{1'b0}}));
    chk(got_b == exp_b, {tag, " bits"}, 32'(got_b), 32'(exp_b));
    chk(ready == exp_rdy, {tag, " ready R8"}, 32'(ready), 32'(exp_rdy));
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(sdo == 1'b0 && sdo_en == 1'b0, "R10 outputs", {30'd0, sdo, sdo_en}, 32'd0);
    chk(ready == 1'b0, "R10 ready", 32'(ready), 32'd0);
    rst_n = 1'b1;
    idle(2);

    // R8 lock interval, then R1/R2 frames in rising capture mode
    for (int w = 0; w < LOCK; w++) word(DW'(w + 1), DW'(w + 1), 2'b00, 2'b00, "R8 lock");
    for (int w = 0; w < 24; w++) begin
      logic [DW-1:0] p;
      if (w < DW) p = DW'(1) << w;
      else if (w == DW) p = '0;
      else if (w == DW + 1) p = '1;
      else p = DW'(w * 37 + 5);
      word(p, ~p, 2'b00, 2'b00, "R1 R2 data");
    end

    // R3 falling capture: mid-period value must be framed
    edge_r = 1'b0; idle(1);
    for (int w = 0; w < 12; w++) word(DW'(w * 91), DW'(w * 53 + 3), 2'b00, 2'b00, "R3 mid capture");
    edge_r = 1'b1; idle(1);
    word(10'h155, 10'h2aa, 2'b00, 2'b00, "R3 back to strobe capture");

    // R5 mid-period pulses are not sampled
    word(10'h0f0, 10'h0f0, 2'b00, 2'b11, "R5 pulse between strobes");
    word(10'h00f, 10'h00f, 2'b00, 2'b00, "R5 no sync after pulse");

    // R4 R6 short request gives the minimum burst
    word(10'h3c3, 10'h3c3, 2'b01, 2'b00, "R4 R6 sync start");
    for (int w = 0; w < SMIN + 2; w++) word(DW'(w + 7), DW'(w + 7), 2'b00, 2'b00, "R6 burst tail");

    // R6 long request from the second line, then both lines
    for (int w = 0; w < SMIN + 3; w++) word(DW'(w * 11), 10'h3ff, 2'b10, 2'b10, "R5 R6 long request");
    word(10'h123, 10'h123, 2'b00, 2'b00, "R6 request released");
    word(10'h321, 10'h321, 2'b11, 2'b00, "R5 both lines");
    for (int w = 0; w < SMIN; w++) word(DW'(w), DW'(w), 2'b00, 2'b00, "R6 tail after both");

    // R9 enable low during data and during a burst
    oe = 1'b0;
    word(10'h1e1, 10'h1e1, 2'b00, 2'b00, "R9 disabled data");
    word(10'h2d2, 10'h2d2, 2'b01, 2'b00, "R9 disabled sync");
    word(10'h0aa, 10'h0aa, 2'b00, 2'b00, "R9 disabled burst");
    oe = 1'b1;
    for (int w = 0; w < 4; w++) word(DW'(w * 200), DW'(w * 200), 2'b00, 2'b00, "R9 resumed");

    // R7 power-down in the middle of a burst, then R8 relock
    word(10'h111, 10'h111, 2'b01, 2'b00, "R7 burst before power-down");
    pwr = 1'b0;
    word(10'h222, 10'h222, 2'b00, 2'b00, "R7 powered down");
    word(10'h333, 10'h333, 2'b01, 2'b00, "R7 request while down");
    pwr = 1'b1; idle(1);
    for (int w = 0; w < LOCK; w++) word(DW'(w + 40), DW'(w + 40), 2'b00, 2'b00, "R8 relock");
    for (int w = 0; w < 4; w++) word(DW'(w * 77 + 1), DW'(w * 77 + 1), 2'b00, 2'b00, "R7 R8 data after relock");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule